// File: doc/BRIEF.md
# Local bus hold arbiter

This block decides which agent drives a PC-style system bus: the CPU (the default owner), a DMA controller, an ISA bus master, or a local-bus master that uses an active-low request/grant pair. DMA and ISA master ownership needs the CPU off the bus. The arbiter raises the CPU HOLD line and waits for HLDA before it issues either grant. A local master gets the bus directly. When DMA asks for the bus, the local master is asked to give it back by withdrawing its grant.

A hidden DRAM refresh engine is arbitrated on a separate path and does not take the CPU off the bus. Refresh is interlocked against DMA and against ordinary ISA cycles run on behalf of the CPU or local master, so no two of them overlap. A software throttle request is ORed onto the HOLD line. It never takes part in the grant decision. While it holds the CPU off the bus, DMA or an ISA master can be granted straight away.

All request inputs are sampled on the rising clock edge. Every grant and the HOLD line come from registers and change one cycle after the edge that sees the cause.

Top module: `bus_hold_arb`

## Requirements
- R1: While reset is asserted and right after it is released, hold_o, dma_gnt, isam_gnt, rfsh_gnt and isa_cyc_gnt are 0, and lm_gnt_n is 1.
- R2: At most one of dma_gnt, isam_gnt and the local grant (lm_gnt_n low) is active. If dma_req and isam_req are both pending when HLDA arrives, DMA is granted.
- R3: A DMA or ISA master request seen with HLDA low raises hold_o one cycle later. The grant is issued only on the edge after HLDA is sampled high while hold_o is high.
- R4: rfsh_gnt and dma_gnt are never both 1. When refresh and DMA requests are both pending, the refresh is granted first. DMA is granted only after the refresh grant has dropped. A refresh request made during DMA ownership waits until dma_gnt has been 0 for one cycle.
- R5: A refresh request arriving while the CPU or the local master owns the bus is granted one cycle later. It leaves hold_o and lm_gnt_n unchanged. The refresh grant falls one cycle after its request falls.
- R6: rfsh_gnt and isa_cyc_gnt are never both 1. A refresh request waits for an active ISA cycle grant to fall. An ISA cycle request waits while a refresh is requested or granted. Each of these grants is held while its request stays high.
- R7: With the bus idle, lm_req_n low (active) gives lm_gnt_n low one cycle later. lm_req_n high while the local master holds the bus sets lm_gnt_n high one cycle later.
- R8: A DMA request while the local master holds the bus sets lm_gnt_n high one cycle later. hold_o stays low until lm_req_n has been sampled high, and rises one cycle after that.
- R9: thr_hold high sets hold_o high one cycle later, whatever the grant state. thr_hold by itself issues no grant.
- R10: If hold_o and cpu_hlda are already high while the CPU owns the bus, a DMA or ISA master request is granted one cycle after it is seen.
- R11: After isam_req falls, isam_gnt drops but hold_o stays high. Neither the CPU nor the local master regains the bus until isam_n (low = ISA master still driving) has been sampled high.
- R12: dma_gnt falls one cycle after dma_req falls. hold_o falls with it unless thr_hold is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_hlda | input | 1 | CPU hold acknowledge |
| hold_o | output | 1 | CPU HOLD request (arbitration OR throttle) |
| thr_hold | input | 1 | Software throttle HOLD request |
| dma_req | input | 1 | DMA bus request, held for the transfer |
| dma_gnt | output | 1 | DMA bus grant |
| isam_req | input | 1 | ISA master bus request |
| isam_n | input | 1 | ISA master active, active low |
| isam_gnt | output | 1 | ISA master bus grant |
| lm_req_n | input | 1 | Local master request, active low |
| lm_gnt_n | output | 1 | Local master grant, active low |
| rfsh_req | input | 1 | Hidden refresh request, held for the refresh |
| rfsh_gnt | output | 1 | Hidden refresh grant |
| isa_cyc_req | input | 1 | ISA cycle request from the CPU or local master |
| isa_cyc_gnt | output | 1 | ISA cycle grant |

## Verification
Some safety properties are checked on every cycle:
- refresh never overlaps DMA or an ISA cycle;
- at most one bus owner holds a grant;
- the local grant is never low during DMA;
- DMA and ISA master grants always follow a sampled HLDA with HOLD high;
- the throttle always shows up on HOLD;
- the local master is not re-granted while the ISA master signal was low.

Only the directed scenarios can show ordering and latency:
- refresh winning a tie against DMA;
- the two-step preemption of the local master;
- the extra idle cycle before a refresh that follows DMA;
- the immediate grant under a throttle HOLD;
- HOLD held through the ISA master drain.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [2:0] {
    OWN_CPU        = 3'd0,
    OWN_LM         = 3'd1,
    OWN_LM_YIELD   = 3'd2,
    OWN_HOLD_WAIT  = 3'd3,
    OWN_DMA        = 3'd4,
    OWN_ISAM       = 3'd5,
    OWN_ISAM_DRAIN = 3'd6
  } owner_e;

  // States in which the CPU must be kept off the bus by HOLD.
  function automatic logic needs_hold(input owner_e s);
    return (s == OWN_HOLD_WAIT) || (s == OWN_DMA) ||
           (s == OWN_ISAM) || (s == OWN_ISAM_DRAIN);
  endfunction

  // Fixed priority among the HOLD-based owners: DMA before ISA master.
  function automatic owner_e pick_hold_owner(input logic dma, input logic isam);
    if (dma)       return OWN_DMA;
    else if (isam) return OWN_ISAM;
    else           return OWN_CPU;
  endfunction

  // A held grant persists while its request stays; a fresh one needs a free path.
  function automatic logic grant_next(input logic granted, input logic req,
                                      input logic path_free);
    return granted ? req : (req && path_free);
  endfunction

endpackage

// File: rtl/bha_refresh_lock.sv
module bha_refresh_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_req,
  input  logic isa_cyc_req,
  input  logic host_busy,
  output logic rfsh_gnt,
  output logic isa_cyc_gnt,
  output logic rfsh_block
);
  import bha_pkg::*;

  logic rfsh_free, isa_free;

  // Refresh needs no ISA cycle in flight and no DMA or ISA master owner.
  assign rfsh_free = !isa_cyc_gnt && !host_busy;
  // ISA cycles yield to any pending or running refresh (refresh has priority).
  assign isa_free  = !rfsh_req && !rfsh_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfsh_gnt    <= 1'b0;
      isa_cyc_gnt <= 1'b0;
    end else begin
      rfsh_gnt    <= grant_next(rfsh_gnt, rfsh_req, rfsh_free);
      isa_cyc_gnt <= grant_next(isa_cyc_gnt, isa_cyc_req, isa_free);
    end
  end

  // Blocks new DMA / ISA master grants while a refresh is wanted or running.
  assign rfsh_block = rfsh_req || rfsh_gnt;

endmodule

// File: rtl/bha_owner_fsm.sv
module bha_owner_fsm (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_hlda,
  input  logic            thr_hold,
  input  logic            dma_req,
  input  logic            isam_req,
  input  logic            isam_n,
  input  logic            lm_req_n,
  input  logic            rfsh_block,
  output bha_pkg::owner_e owner,
  output logic            hold_q
);
  import bha_pkg::*;

  owner_e nxt;
  logic   hold_req;
  logic   cpu_off;

  assign hold_req = dma_req || isam_req;
  // CPU already off the bus (e.g. by throttle) and no refresh in the way.
  assign cpu_off  = cpu_hlda && hold_q && !rfsh_block;

  always_comb begin
    nxt = owner;
    unique case (owner)
      OWN_CPU: begin
        if (hold_req)
          nxt = cpu_off ? pick_hold_owner(dma_req, isam_req) : OWN_HOLD_WAIT;
        else if (!lm_req_n)
          nxt = OWN_LM;
      end
      OWN_LM: begin
        if (dma_req)       nxt = OWN_LM_YIELD;
        else if (lm_req_n) nxt = OWN_CPU;
      end
      OWN_LM_YIELD: begin
        if (lm_req_n) nxt = OWN_HOLD_WAIT;
      end
      OWN_HOLD_WAIT: begin
        if (!hold_req)
          nxt = OWN_CPU;
        else if (cpu_hlda && !rfsh_block)
          nxt = pick_hold_owner(dma_req, isam_req);
      end
      OWN_DMA: begin
        if (!dma_req) nxt = OWN_CPU;
      end
      OWN_ISAM: begin
        if (!isam_req) nxt = OWN_ISAM_DRAIN;
      end
      OWN_ISAM_DRAIN: begin
        if (isam_n) nxt = OWN_CPU;
      end
      default: nxt = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner  <= OWN_CPU;
      hold_q <= 1'b0;
    end else begin
      owner  <= nxt;
      hold_q <= needs_hold(nxt) || thr_hold;
    end
  end

endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_hlda,
  output logic hold_o,
  input  logic thr_hold,
  input  logic dma_req,
  output logic dma_gnt,
  input  logic isam_req,
  input  logic isam_n,
  output logic isam_gnt,
  input  logic lm_req_n,
  output logic lm_gnt_n,
  input  logic rfsh_req,
  output logic rfsh_gnt,
  input  logic isa_cyc_req,
  output logic isa_cyc_gnt
);
  import bha_pkg::*;

  owner_e owner_w;
  logic   host_busy_w;
  logic   rfsh_block_w;

  bha_owner_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_hlda   (cpu_hlda),
    .thr_hold   (thr_hold),
    .dma_req    (dma_req),
    .isam_req   (isam_req),
    .isam_n     (isam_n),
    .lm_req_n   (lm_req_n),
    .rfsh_block (rfsh_block_w),
    .owner      (owner_w),
    .hold_q     (hold_o)
  );

  bha_refresh_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .rfsh_req    (rfsh_req),
    .isa_cyc_req (isa_cyc_req),
    .host_busy   (host_busy_w),
    .rfsh_gnt    (rfsh_gnt),
    .isa_cyc_gnt (isa_cyc_gnt),
    .rfsh_block  (rfsh_block_w)
  );

  // Grants decode straight from the registered owner state.
  assign dma_gnt     = (owner_w == OWN_DMA);
  assign isam_gnt    = (owner_w == OWN_ISAM);
  assign lm_gnt_n    = (owner_w != OWN_LM);
  assign host_busy_w = dma_gnt || isam_gnt;

endmodule

// File: rtl/bha_chk.sv
module bha_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_hlda,
  input logic hold_o,
  input logic thr_hold,
  input logic dma_req,
  input logic dma_gnt,
  input logic isam_n,
  input logic isam_gnt,
  input logic lm_gnt_n,
  input logic rfsh_gnt,
  input logic isa_cyc_gnt,
  input logic rfsh_block_w
);

  // R4
  no_rfsh_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh_gnt && dma_gnt));

  // R4
  dma_after_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt) |-> !$past(rfsh_block_w));

  // R6
  no_rfsh_isa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfsh_gnt && isa_cyc_gnt));

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_gnt, isam_gnt, !lm_gnt_n}));

  // R3
  dma_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_gnt) |-> ($past(cpu_hlda) && $past(hold_o)));

  // R3
  isam_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isam_gnt) |-> ($past(cpu_hlda) && $past(hold_o)));

  // R8
  lm_off_in_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |-> lm_gnt_n);

  // R9
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hold |=> hold_o);

  // R11
  lm_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lm_gnt_n) |-> $past(isam_n));

  // R12
  dma_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && !dma_req) |=> !dma_gnt);

endmodule

bind bus_hold_arb bha_chk u_bha_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_hlda     (cpu_hlda),
  .hold_o       (hold_o),
  .thr_hold     (thr_hold),
  .dma_req      (dma_req),
  .dma_gnt      (dma_gnt),
  .isam_n       (isam_n),
  .isam_gnt     (isam_gnt),
  .lm_gnt_n     (lm_gnt_n),
  .rfsh_gnt     (rfsh_gnt),
  .isa_cyc_gnt  (isa_cyc_gnt),
  .rfsh_block_w (rfsh_block_w)
);

// File: tb/bus_hold_arb_tb_top.sv
module bus_hold_arb_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_hlda = 1'b0, thr_hold = 1'b0, dma_req = 1'b0, isam_req = 1'b0;
  logic isam_n = 1'b1, lm_req_n = 1'b1, rfsh_req = 1'b0, isa_cyc_req = 1'b0;
  logic hold_o, dma_gnt, isam_gnt, lm_gnt_n, rfsh_gnt, isa_cyc_gnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_hold_arb dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_hlda(cpu_hlda), .hold_o(hold_o),
    .thr_hold(thr_hold), .dma_req(dma_req), .dma_gnt(dma_gnt),
    .isam_req(isam_req), .isam_n(isam_n), .isam_gnt(isam_gnt),
    .lm_req_n(lm_req_n), .lm_gnt_n(lm_gnt_n), .rfsh_req(rfsh_req),
    .rfsh_gnt(rfsh_gnt), .isa_cyc_req(isa_cyc_req), .isa_cyc_gnt(isa_cyc_gnt)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1", "hold_o in reset", hold_o, 1'b0);
    chk("R1", "lm_gnt_n in reset", lm_gnt_n, 1'b1);
    rst_n = 1'b1;
    step();
    chk("R1", "hold_o", hold_o, 1'b0);
    chk("R1", "dma_gnt", dma_gnt, 1'b0);
    chk("R1", "isam_gnt", isam_gnt, 1'b0);
    chk("R1", "rfsh_gnt", rfsh_gnt, 1'b0);
    chk("R1", "isa_cyc_gnt", isa_cyc_gnt, 1'b0);
    chk("R1", "lm_gnt_n", lm_gnt_n, 1'b1);
  endtask

  task automatic t_dma_handshake();
    dma_req = 1'b1;
    step();
    chk("R3", "hold raised", hold_o, 1'b1);
    chk("R3", "no grant before hlda", dma_gnt, 1'b0);
    step();
    chk("R3", "still no grant with hlda low", dma_gnt, 1'b0);
    cpu_hlda = 1'b1;
    step();
    chk("R3", "grant after hlda", dma_gnt, 1'b1);
    dma_req = 1'b0;
    step();
    chk("R12", "dma_gnt released", dma_gnt, 1'b0);
    chk("R12", "hold released", hold_o, 1'b0);
    cpu_hlda = 1'b0;
    step();
  endtask

  task automatic t_priority();
    dma_req = 1'b1; isam_req = 1'b1;
    step();
    cpu_hlda = 1'b1;
    step();
    chk("R2", "dma wins", dma_gnt, 1'b1);
    chk("R2", "isam loses", isam_gnt, 1'b0);
    dma_req = 1'b0; isam_req = 1'b0;
    step();
    cpu_hlda = 1'b0;
    step();
  endtask

  task automatic t_isam_drain();
    isam_req = 1'b1;
    step();
    cpu_hlda = 1'b1;
    step();
    chk("R3", "isam granted", isam_gnt, 1'b1);
    isam_n = 1'b0; lm_req_n = 1'b0; isam_req = 1'b0;
    step();
    chk("R11", "isam_gnt dropped", isam_gnt, 1'b0);
    chk("R11", "hold kept in drain", hold_o, 1'b1);
    step();
    chk("R11", "hold still kept", hold_o, 1'b1);
    chk("R11", "lm not granted in drain", lm_gnt_n, 1'b1);
    isam_n = 1'b1;
    step();
    chk("R11", "hold dropped after isam_n high", hold_o, 1'b0);
    cpu_hlda = 1'b0;
    step();
    chk("R7", "lm granted", lm_gnt_n, 1'b0);
    lm_req_n = 1'b1;
    step();
    chk("R7", "lm released", lm_gnt_n, 1'b1);
  endtask

  task automatic t_preempt();
    lm_req_n = 1'b0;
    step();
    chk("R7", "lm granted from idle", lm_gnt_n, 1'b0);
    dma_req = 1'b1;
    step();
    chk("R8", "lm grant withdrawn", lm_gnt_n, 1'b1);
    chk("R8", "no hold before release", hold_o, 1'b0);
    step();
    chk("R8", "still no hold", hold_o, 1'b0);
    lm_req_n = 1'b1;
    step();
    chk("R8", "hold after release", hold_o, 1'b1);
    cpu_hlda = 1'b1;
    step();
    chk("R8", "dma granted after release", dma_gnt, 1'b1);
    dma_req = 1'b0;
    step();
    cpu_hlda = 1'b0;
    step();
  endtask

  task automatic t_rfsh_hidden();
    lm_req_n = 1'b0;
    step();
    rfsh_req = 1'b1;
    step();
    chk("R5", "refresh granted", rfsh_gnt, 1'b1);
    chk("R5", "no hold for refresh", hold_o, 1'b0);
    chk("R5", "lm keeps bus", lm_gnt_n, 1'b0);
    rfsh_req = 1'b0;
    step();
    chk("R5", "refresh released", rfsh_gnt, 1'b0);
    lm_req_n = 1'b1;
    step();
  endtask

  task automatic t_rfsh_dma();
    rfsh_req = 1'b1; dma_req = 1'b1;
    step();
    chk("R4", "refresh wins tie", rfsh_gnt, 1'b1);
    cpu_hlda = 1'b1;
    step();
    chk("R4", "dma blocked by refresh", dma_gnt, 1'b0);
    rfsh_req = 1'b0;
    step();
    chk("R4", "refresh dropped", rfsh_gnt, 1'b0);
    chk("R4", "dma not yet", dma_gnt, 1'b0);
    step();
    chk("R4", "dma after refresh", dma_gnt, 1'b1);
    rfsh_req = 1'b1;
    step();
    chk("R4", "refresh blocked during dma", rfsh_gnt, 1'b0);
    dma_req = 1'b0;
    step();
    chk("R4", "refresh waits one more cycle", rfsh_gnt, 1'b0);
    chk("R12", "dma dropped", dma_gnt, 1'b0);
    step();
    chk("R4", "refresh after dma", rfsh_gnt, 1'b1);
    rfsh_req = 1'b0; cpu_hlda = 1'b0;
    step(2);
  endtask

  task automatic t_rfsh_isa();
    isa_cyc_req = 1'b1;
    step();
    chk("R6", "isa cycle granted", isa_cyc_gnt, 1'b1);
    rfsh_req = 1'b1;
    step(2);
    chk("R6", "refresh waits for isa cycle", rfsh_gnt, 1'b0);
    chk("R6", "isa cycle held", isa_cyc_gnt, 1'b1);
    isa_cyc_req = 1'b0;
    step();
    chk("R6", "refresh still off", rfsh_gnt, 1'b0);
    step();
    chk("R6", "refresh after isa cycle", rfsh_gnt, 1'b1);
    isa_cyc_req = 1'b1;
    step();
    chk("R6", "isa cycle waits for refresh", isa_cyc_gnt, 1'b0);
    rfsh_req = 1'b0;
    step();
    chk("R6", "isa still waits", isa_cyc_gnt, 1'b0);
    step();
    chk("R6", "isa cycle after refresh", isa_cyc_gnt, 1'b1);
    isa_cyc_req = 1'b0;
    step();
  endtask

  task automatic t_throttle();
    thr_hold = 1'b1;
    step();
    chk("R9", "throttle raises hold", hold_o, 1'b1);
    chk("R9", "no grant from throttle", dma_gnt | isam_gnt, 1'b0);
    cpu_hlda = 1'b1;
    step();
    dma_req = 1'b1;
    step();
    chk("R10", "dma granted at once", dma_gnt, 1'b1);
    dma_req = 1'b0;
    step();
    chk("R12", "dma released", dma_gnt, 1'b0);
    chk("R9", "hold kept by throttle", hold_o, 1'b1);
    thr_hold = 1'b0;
    step();
    chk("R9", "hold drops with throttle", hold_o, 1'b0);
    cpu_hlda = 1'b0;
    step();
  endtask

  initial begin
    step(2);
    t_reset();
    t_dma_handshake();
    t_priority();
    t_isam_drain();
    t_preempt();
    t_rfsh_hidden();
    t_rfsh_dma();
    t_rfsh_isa();
    t_throttle();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule